// File: doc/BRIEF.md
# Video RAM host port with read-ahead

This block is the processor side of a video display controller's memory access path. A host sees three byte-wide ports: a control port that takes a two-byte address setup, a data port for reads and a data port for writes. Behind them sit one 14-bit address counter and a one-byte read-ahead register. Toward video memory the block issues single-byte requests on a request/acknowledge interface and waits for each to complete.

There is no read mode and no write mode. One bit of the setup sequence decides only whether a memory read into the read-ahead register starts as soon as the address is loaded. A host read returns the byte fetched earlier and then fetches the next one. A host write stores its byte at the counter. Both advance the same counter, so a host can mix reads and writes, for example reading to skip over bytes it must not change.

Top module: `vram_host_port`

## Requirements
- R1: After reset the address counter is 0x0000, the read-ahead register and `rd_data` are 0x00, `rd_valid`, `busy` and `mem_req` are low, and the control port expects its first (low) byte.
- R2: Two accepted control writes load the counter. The first byte is address bits 7:0. Bits 5:0 of the second byte are address bits 13:8. Bits 7:6 of the second byte are not address bits.
- R3: If bit 6 of the second control byte is 0, the next cycle brings a memory read at the loaded address. Its byte goes into the read-ahead register and the counter then becomes the loaded address plus one.
- R4: If bit 6 of the second control byte is 1, no memory request follows and the counter holds the loaded address.
- R5: An accepted data read presents the read-ahead register on `rd_data` with `rd_valid` high for one cycle in the next cycle. It then reads memory at the counter into the read-ahead register and increments the counter.
- R6: An accepted data write issues a memory write of that byte at the counter, increments the counter when the write completes, and also places the byte in the read-ahead register.
- R7: A read that follows an address load with bit 6 set returns the last byte transferred, not the byte at the loaded address.
- R8: Loading address A-1 with bit 6 clear and loading A with bit 6 set place the following data writes at the same memory addresses.
- R9: Within a run of writes, each data read advances the counter by one without changing memory. In four-byte records, writing two bytes, reading twice, then writing two bytes updates bytes 0 and 1 of two consecutive records.
- R10: The counter wraps from 0x3FFF to 0x0000 when it increments.
- R11: `busy` equals `mem_req`. While it is high, data reads, data writes and control writes are ignored and change neither the counter nor the control byte order.
- R12: An accepted data read or data write resets the control port to expect the low byte.
- R13: Once `mem_req` rises, it and `mem_addr`, `mem_we` and `mem_wdata` hold steady until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control port byte write strobe (lowest priority) |
| ctrl_wdata | input | 8 | Control port byte |
| rd_req | input | 1 | Data read strobe (highest priority) |
| rd_data | output | 8 | Byte returned by the last accepted read |
| rd_valid | output | 1 | One-cycle pulse: rd_data is new |
| wr_req | input | 1 | Data write strobe (beats control write) |
| wr_wdata | input | 8 | Byte to write |
| busy | output | 1 | A memory request is outstanding; host strobes are ignored |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 14 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory completion; read data is valid with it |
| mem_rdata | input | 8 | Memory read byte |

## Verification
A host strobe taken at a clock edge drives `rd_valid` with `rd_data`, and `mem_req` with its address, from that same edge. The counter steps on the edge at which `mem_ack` is sampled. The bench therefore changes inputs on falling edges and compares each read result on the falling edge that follows the accepting rising edge. The memory model compares each request's address, direction and data on the falling edge where it raises its acknowledge, two cycles after the request appears. Every expected read byte and memory operation is pushed into a queue when the host access is issued. The monitors pop and compare them in order, so a missing, extra or misplaced access shows as a mismatch or as an item left over at the end.

// File: rtl/vhp_pkg.sv
// Shared types for the video RAM host port.
// Assumes: one memory operation at a time.
package vhp_pkg;
    typedef enum logic [1:0] {
        VHP_OP_NONE = 2'd0,
        VHP_OP_RD   = 2'd1,
        VHP_OP_WR   = 2'd2
    } vhp_op_e;
endpackage

// File: rtl/vhp_addr_ctr.sv
// Video memory address counter: loads a full address or steps by one with wrap.
// Assumes load_en and inc_en are never high together (the top guarantees it).
module vhp_addr_ctr #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    input  logic          inc_en,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Hold, load or step the counter; the adder wraps at the top address.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (load_en) addr <= load_val;
        else if (inc_en)  addr <= addr + ONE;
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !inc_en) |=> $stable(addr));

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !load_en && (&addr)) |=> (addr == '0));
endmodule

// File: rtl/vhp_mem_seq.sv
// Memory request sequencer: issues one read or write, holds it until acknowledged,
// and owns the read-ahead register.
// Assumes start is only non-NONE while no request is outstanding.
module vhp_mem_seq
    import vhp_pkg::*;
#(
    parameter int AW = 14,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vhp_op_e       start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] prefetch,
    output logic          done
);
    // A request finishes in the cycle its acknowledge is seen.
    always_comb done = mem_req && mem_ack;

    // Launch, hold and retire requests; capture read data or written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            prefetch  <= '0;
        end else if (done) begin
            mem_req <= 1'b0;
            if (!mem_we) prefetch <= mem_rdata;
        end else if (!mem_req) begin
            case (start)
                VHP_OP_RD: begin
                    mem_req  <= 1'b1;
                    mem_we   <= 1'b0;
                    mem_addr <= addr_in;
                end
                VHP_OP_WR: begin
                    mem_req   <= 1'b1;
                    mem_we    <= 1'b1;
                    mem_addr  <= addr_in;
                    mem_wdata <= wdata_in;
                    prefetch  <= wdata_in;
                end
                default: ;
            endcase
        end
    end

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R5
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we) |=> !mem_req);
endmodule

// File: rtl/vram_host_port.sv
// Host access port of a video memory: two-byte address setup, read-ahead data reads,
// data writes, one shared address counter, and a request/acknowledge memory side.
// Assumes host strobes are single-cycle pulses; strobes while busy are dropped.
module vram_host_port
    import vhp_pkg::*;
#(
    parameter int AW      = 14,
    parameter int DW      = 8,
    parameter int INH_BIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] ctrl_wdata,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_wdata,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam int HI_BITS = AW - DW;

    logic          acc_rd, acc_wr, acc_ctrl, ctrl_load, hi_next, seq_done;
    logic [DW-1:0] lo_q, prefetch;
    logic [AW-1:0] addr, load_val, seq_addr;
    vhp_op_e       seq_op;

    // Busy mirrors the outstanding request.
    always_comb busy = mem_req;

    // Accept at most one host strobe per cycle: read, then write, then control.
    always_comb begin
        acc_rd    = rd_req && !busy;
        acc_wr    = wr_req && !busy && !rd_req;
        acc_ctrl  = ctrl_wr && !busy && !rd_req && !wr_req;
        ctrl_load = acc_ctrl && hi_next;
        load_val  = {ctrl_wdata[HI_BITS-1:0], lo_q};
    end

    // Pick the memory operation and its address for this cycle.
    always_comb begin
        seq_op   = VHP_OP_NONE;
        seq_addr = addr;
        if (acc_rd)      seq_op = VHP_OP_RD;
        else if (acc_wr) seq_op = VHP_OP_WR;
        else if (ctrl_load && !ctrl_wdata[INH_BIT]) begin
            seq_op   = VHP_OP_RD;
            seq_addr = load_val;
        end
    end

    // Track which control byte comes next; data accesses restart the pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_next <= 1'b0;
        else if (acc_rd || acc_wr)  hi_next <= 1'b0;
        else if (acc_ctrl)          hi_next <= !hi_next;
    end

    // Keep the low address byte until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                    lo_q <= '0;
        else if (acc_ctrl && !hi_next) lo_q <= ctrl_wdata;
    end

    // Return the read-ahead byte held before the new fetch starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= acc_rd;
            if (acc_rd) rd_data <= prefetch;
        end
    end

    vhp_addr_ctr #(.AW(AW)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ctrl_load),
        .load_val (load_val),
        .inc_en   (seq_done),
        .addr     (addr)
    );

    vhp_mem_seq #(.AW(AW), .DW(DW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_op),
        .addr_in   (seq_addr),
        .wdata_in  (wr_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .prefetch  (prefetch),
        .done      (seq_done)
    );

    // R11
    busy_rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);

    // R4
    inhibit_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_load && ctrl_wdata[INH_BIT]) |=> (!mem_req && addr == $past(load_val)));

    // R3
    load_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_load && !ctrl_wdata[INH_BIT]) |=> (mem_req && !mem_we && mem_addr == addr));

    // R5
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !busy) |=> (rd_valid && mem_req && !mem_we));

    // R12
    pair_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || wr_req) && !busy) |=> !hi_next);
endmodule

// File: tb/vram_host_port_tb_top.sv
`timescale 1ns/1ps
module vram_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
    logic [7:0]  ctrl_wdata = '0, wr_wdata = '0;
    logic [7:0]  rd_data, mem_wdata;
    logic        rd_valid, busy, mem_req, mem_we;
    logic [13:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #2 clk = ~clk;

    vram_host_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_req(wr_req), .wr_wdata(wr_wdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct { bit we; int addr; logic [7:0] data; string tag; } op_t;
    typedef struct { logic [7:0] data; string tag; } rd_t;

    op_t exp_ops[$];
    rd_t exp_rds[$];
    logic [7:0] mem_m [int];
    logic [7:0] shadow [int];
    int tests = 0, fails = 0;
    bit done = 0;
    string cur = "R1";

    // bench model of the port
    int m_addr = 0, m_lo = 0;
    bit m_hi = 0;
    logic [7:0] m_pref = '0;

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] sh_byte(int a);
        return shadow.exists(a) ? shadow[a] : init_byte(a);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory model: acknowledge two cycles after a request, compare with expectation
    int lat = 0;
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat = 0;
        end else if (rst_n && mem_req) begin
            lat++;
            if (lat >= 2) begin
                int a;
                a = int'(mem_addr);
                if (exp_ops.size() == 0) begin
                    chk("R11", "unexpected mem op addr", 32'(a), 32'hFFFF);
                end else begin
                    op_t e;
                    e = exp_ops.pop_front();
                    chk(e.tag, "mem op we", 32'(mem_we), 32'(e.we));
                    chk(e.tag, "mem op addr", 32'(a), 32'(e.addr));
                    if (e.we) chk(e.tag, "mem op wdata", 32'(mem_wdata), 32'(e.data));
                end
                if (mem_we) mem_m[a] = mem_wdata;
                mem_rdata <= mem_m.exists(a) ? mem_m[a] : init_byte(a);
                mem_ack <= 1'b1;
            end
        end
    end

    // read monitor: every rd_valid pops one expected byte
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_rds.size() == 0) begin
                chk("R11", "unexpected rd_valid data", 32'(rd_data), 32'hFFFF);
            end else begin
                rd_t e;
                e = exp_rds.pop_front();
                chk(e.tag, "rd_data", 32'(rd_data), 32'(e.data));
            end
        end
    end

    task automatic wait_idle();
        while (busy || mem_ack) @(negedge clk);
    endtask

    task automatic expect_fetch();
        exp_ops.push_back('{we: 1'b0, addr: m_addr, data: 8'h00, tag: cur});
        m_pref = sh_byte(m_addr);
        m_addr = (m_addr + 1) & 16'h3FFF;
    endtask

    task automatic host_ctrl(logic [7:0] b);
        wait_idle();
        if (!m_hi) begin
            m_lo = int'(b);
            m_hi = 1;
        end else begin
            m_hi = 0;
            m_addr = (int'(b[5:0]) << 8) | m_lo;
            if (!b[6]) expect_fetch();
        end
        ctrl_wr = 1'b1; ctrl_wdata = b;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic host_read();
        wait_idle();
        exp_rds.push_back('{data: m_pref, tag: cur});
        m_hi = 0;
        expect_fetch();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic host_write(logic [7:0] d);
        wait_idle();
        exp_ops.push_back('{we: 1'b1, addr: m_addr, data: d, tag: cur});
        shadow[m_addr] = d;
        m_pref = d;
        m_addr = (m_addr + 1) & 16'h3FFF;
        m_hi = 0;
        wr_req = 1'b1; wr_wdata = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic settle();
        wait_idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "mem_req", 32'(mem_req), 0);
        chk("R1", "rd_valid", 32'(rd_valid), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
        // R1: first read returns cleared read-ahead, fetches address 0
        host_read();
        settle();

        // R2, R3: load 0x1234 with fetch, then read the fetched byte (R5)
        cur = "R3";
        host_ctrl(8'h34); host_ctrl(8'h12);
        cur = "R5";
        host_read(); host_read();
        settle();

        // R2: bit 7 of the high byte is not an address bit
        cur = "R2";
        host_ctrl(8'h10); host_ctrl(8'hA5);
        host_read();
        settle();

        // R4: inhibited load issues no request; R6 writes follow
        cur = "R4";
        host_ctrl(8'h00); host_ctrl(8'h52);
        settle();
        chk("R4", "mem_req after inhibited load", 32'(mem_req), 0);
        cur = "R6";
        host_write(8'hA5); host_write(8'h5A);
        settle();

        // R7: stale read after inhibited load returns last transferred byte
        cur = "R7";
        host_ctrl(8'h00); host_ctrl(8'h60);
        host_read();
        settle();

        // R8: A-1 with fetch versus A with inhibit, same write address
        cur = "R8";
        host_ctrl(8'hFF); host_ctrl(8'h2F);
        host_write(8'h11);
        host_ctrl(8'h00); host_ctrl(8'h70);
        host_write(8'h22);
        settle();
        // read back both through the normal interface
        host_ctrl(8'h00); host_ctrl(8'h30);
        host_read();
        settle();

        // R9: four-byte records, write two, skip two by reading, write two
        cur = "R9";
        host_ctrl(8'h00); host_ctrl(8'h43);
        host_write(8'h40); host_write(8'h50);
        host_read(); host_read();
        host_write(8'h41); host_write(8'h51);
        settle();
        host_ctrl(8'h00); host_ctrl(8'h03);
        repeat (6) host_read();
        settle();

        // R10: counter wraps at the top address
        cur = "R10";
        host_ctrl(8'hFF); host_ctrl(8'h7F);
        host_write(8'h77); host_write(8'h88);
        host_read();
        settle();

        // R11: strobes while busy are dropped
        cur = "R11";
        host_ctrl(8'h00); host_ctrl(8'h45);
        host_write(8'h31);
        rd_req = 1'b1; wr_req = 1'b1; wr_wdata = 8'hEE;
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        ctrl_wr = 1'b1; ctrl_wdata = 8'h00;
        @(negedge clk);
        ctrl_wr = 1'b0;
        host_write(8'h32);
        settle();
        chk("R11", "busy idle", 32'(busy), 0);

        // R12: data read between control bytes restarts the pair
        cur = "R12";
        host_ctrl(8'h55);
        host_read();
        host_ctrl(8'h00); host_ctrl(8'h41);
        host_write(8'h99);
        settle();
        host_ctrl(8'h00); host_ctrl(8'h01);
        host_read();
        settle();

        chk("R5", "read items left", 32'(exp_rds.size()), 0);
        chk("R6", "mem ops left", 32'(exp_ops.size()), 0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            finish_run();
        end
    end
endmodule